// File: doc/BRIEF.md
# Pipelined Descending Sorter for Nine Values

This block takes a full set of nine unsigned words at once and returns the same nine words ranked from largest to smallest. It is a compare-exchange network of the bitonic kind, built for sixteen lanes. The seven lanes beyond the real inputs are filled with zero, and because every compare-exchange sends zeros downward, those filler values settle in the bottom lanes and are dropped at the output. Only the upper nine lanes reach the output bus.

Each of the ten network layers is followed by a register. A new set can enter on every clock, and a sorted set leaves on every clock once the pipeline is full. The delay from input to output is fixed. A valid flag moves through the same registers as the data, so a consumer only watches `out_valid` and never counts cycles. There is no stall or backpressure. A set that is accepted always comes out ten clocks later.

Top module: `desc_sort_pipe`

## Requirements
- R1: While `out_valid` is high, the nine output slots are in descending unsigned order. Slot k sits at `out_data[k*WIDTH +: WIDTH]`, so slot 0 holds the largest value and slot 8 the smallest.
- R2: The nine output values are the nine input values of the same set. Repeated values appear as many times as they were given, and equal values are never merged or lost.
- R3: A set sampled with `in_valid` high is presented with `out_valid` high just after the tenth rising edge, counting the edge that sampled it. `out_valid` is high for exactly one cycle per accepted set.
- R4: Sets given on consecutive cycles are all accepted. Each produces its own result on consecutive cycles, in the order the sets were given.
- R5: On a cycle where `in_valid` is low, `in_data` is ignored. No `out_valid` pulse appears ten edges later, and the neighbouring sets come out unchanged.
- R6: Values are compared as unsigned. A value with its top bit set ranks above every value with that bit clear.
- R7: Zeros in the input come out as zeros in the lowest slots. The zero filler lanes never take the place of a real input, and an all-zero set returns nine zeros.
- R8: `rst_n` is a synchronous, active-low reset that clears only the valid pipeline. `out_valid` is low during reset and stays low after release until a set given after release has travelled through the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register uses the rising edge |
| rst_n | input | 1 | Synchronous active-low reset for the valid pipeline |
| in_valid | input | 1 | The set on `in_data` is taken at this edge |
| in_data | input | NUM_VALS*WIDTH | Nine unsigned values; value k at bits k*WIDTH upward |
| out_valid | output | 1 | `out_data` holds a sorted set this cycle |
| out_data | output | NUM_VALS*WIDTH | Sorted values, largest in slot 0 at the low bits |

## Verification
The network is driven with sets that are already ascending, already descending, all equal, all zero, and a mix of zeros and small numbers. The ascending and descending sets show whether every layer swaps in the right direction. The equal and zero sets show whether values get lost or whether filler lanes leak into the output. A set around the top bit separates an unsigned comparison from a signed one. A long run of random sets given back to back, some drawn from a narrow range to force duplicates, checks throughput and ordering. Gaps with changing data and `in_valid` low check that bubbles stay empty and that each result arrives at exactly the tenth edge.

// File: rtl/sortnet_pkg.sv
// Package: helpers shared by the sorting network.
// Assumes layers are enumerated in bitonic order: for each merge span
// 2,4,8,... the partner distance runs from half the span down to 1.
package sortnet_pkg;

    // Number of layers in a bitonic network over 2**logl lanes.
    function automatic int net_layers(input int logl);
        return (logl * (logl + 1)) / 2;
    endfunction

    // Merge span (block size) used by layer s.
    function automatic int layer_span(input int s);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p <= 16; p++) begin
            for (int q = p; q >= 1; q--) begin
                if (cnt == s) res = 1 << p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Partner distance used by layer s.
    function automatic int layer_dist(input int s);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p <= 16; p++) begin
            for (int q = p; q >= 1; q--) begin
                if (cnt == s) res = 1 << (q - 1);
                cnt++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/sortnet_cex.sv
// Module: one compare-exchange element with no storage.
// Operands are unsigned. When MAX_LOW is 1 the larger value leaves on the
// low-index side (y_lo), otherwise it leaves on the high-index side. Equal
// values go straight through.
module sortnet_cex #(
    parameter int WIDTH   = 16,
    parameter bit MAX_LOW = 1'b1
) (
    input  logic [WIDTH-1:0] a_lo,
    input  logic [WIDTH-1:0] a_hi,
    output logic [WIDTH-1:0] y_lo,
    output logic [WIDTH-1:0] y_hi
);

    logic swap;

    // Decide whether the two operands trade places.
    always_comb begin
        if (MAX_LOW) swap = (a_hi > a_lo);
        else         swap = (a_lo > a_hi);
    end

    // Route the operands according to the swap decision.
    always_comb begin
        y_lo = swap ? a_hi : a_lo;
        y_hi = swap ? a_lo : a_hi;
    end

endmodule

// File: rtl/sortnet_layer.sv
// Module: one registered layer of the bitonic network.
// Pairs lane i with lane i+DIST wherever bit DIST of i is clear. Within each
// SPAN-sized block the direction follows bit SPAN of i, so the last layer
// (SPAN equal to the lane count) orders everything descending. Data
// registers are not reset; only the valid flag is.
module sortnet_layer #(
    parameter int WIDTH = 16,
    parameter int LANES = 16,
    parameter int SPAN  = 2,
    parameter int DIST  = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        v_i,
    input  logic [LANES-1:0][WIDTH-1:0] d_i,
    output logic                        v_o,
    output logic [LANES-1:0][WIDTH-1:0] d_o
);

    logic [LANES-1:0][WIDTH-1:0] d_nxt;

    // One compare-exchange for each lane pair of this layer.
    for (genvar i = 0; i < LANES; i++) begin : g_pair
        if ((i & DIST) == 0) begin : g_cex
            sortnet_cex #(
                .WIDTH  (WIDTH),
                .MAX_LOW(((i & SPAN) == 0) ? 1'b1 : 1'b0)
            ) u_cex (
                .a_lo(d_i[i]),
                .a_hi(d_i[i + DIST]),
                .y_lo(d_nxt[i]),
                .y_hi(d_nxt[i + DIST])
            );
        end
    end

    // Register the layer result; the data path has no reset.
    always_ff @(posedge clk) begin
        d_o <= d_nxt;
    end

    // Carry the valid flag alongside the data and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_o <= 1'b0;
        else        v_o <= v_i;
    end

    // R1: every registered pair keeps the order this layer imposed.
    for (genvar i = 0; i < LANES; i++) begin : g_chk
        if ((i & DIST) == 0) begin : g_pairchk
            if ((i & SPAN) == 0) begin : g_dn
                a_r1_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
                    v_o |-> (d_o[i] >= d_o[i + DIST]));
            end else begin : g_up
                a_r1_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
                    v_o |-> (d_o[i] <= d_o[i + DIST]));
            end
        end
    end

    // R8: the valid flag is clear on the first cycle after reset release.
    a_r8_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !v_o);

endmodule

// File: rtl/desc_sort_pipe.sv
// Module: pipelined descending sorter (top).
// Pads NUM_VALS inputs with zero up to a power-of-two lane count and runs
// them through a registered bitonic network, one register per layer. Only
// the upper NUM_VALS lanes reach the output. Assumes unsigned data, no
// stalls, and a consumer that always takes the output.
module desc_sort_pipe
    import sortnet_pkg::*;
#(
    parameter int NUM_VALS = 9,
    parameter int WIDTH    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [NUM_VALS*WIDTH-1:0] in_data,
    output logic                      out_valid,
    output logic [NUM_VALS*WIDTH-1:0] out_data
);

    localparam int LOGL    = $clog2(NUM_VALS);
    localparam int LANES   = 1 << LOGL;
    localparam int NLAYERS = net_layers(LOGL);
    localparam int CW      = $clog2(NLAYERS + 1);

    logic [NLAYERS:0][LANES-1:0][WIDTH-1:0] st;
    logic [NLAYERS:0]                       vs;

    // Load the real inputs and fill the remaining lanes with zero.
    for (genvar i = 0; i < LANES; i++) begin : g_in
        if (i < NUM_VALS) begin : g_real
            assign st[0][i] = in_data[i*WIDTH +: WIDTH];
        end else begin : g_pad
            assign st[0][i] = '0;
        end
    end
    assign vs[0] = in_valid;

    // The chain of registered network layers.
    for (genvar s = 0; s < NLAYERS; s++) begin : g_layer
        sortnet_layer #(
            .WIDTH(WIDTH),
            .LANES(LANES),
            .SPAN (layer_span(s)),
            .DIST (layer_dist(s))
        ) u_layer (
            .clk  (clk),
            .rst_n(rst_n),
            .v_i  (vs[s]),
            .d_i  (st[s]),
            .v_o  (vs[s+1]),
            .d_o  (st[s+1])
        );
    end

    // Drive the output from the upper lanes of the last layer.
    for (genvar i = 0; i < NUM_VALS; i++) begin : g_out
        assign out_data[i*WIDTH +: WIDTH] = st[NLAYERS][i];
    end
    assign out_valid = vs[NLAYERS];

    // Checker state: edges since reset release, saturating at the depth.
    logic [CW-1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                    since_rst <= '0;
        else if (since_rst < CW'(NLAYERS)) since_rst <= since_rst + 1'b1;
    end

    // R1: the nine output slots are in descending order.
    for (genvar i = 0; i + 1 < NUM_VALS; i++) begin : g_ord
        a_r1_out_desc: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_data[i*WIDTH +: WIDTH] >= out_data[(i+1)*WIDTH +: WIDTH]));
    end

    // R3: no result can appear before a full pipeline depth after reset.
    a_r3_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_rst >= CW'(NLAYERS)));

endmodule

// File: tb/desc_sort_pipe_tb.sv
`timescale 1ns/1ps
module desc_sort_pipe_tb;

    localparam int N   = 9;
    localparam int W   = 16;
    localparam int LAT = 10;

    logic           clk;
    logic           rst_n;
    logic           in_valid;
    logic [N*W-1:0] in_data;
    logic           out_valid;
    logic [N*W-1:0] out_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;
    bit mon_on = 0;

    logic [N*W-1:0] exp_q[$];
    int             due_q[$];
    string          tag_q[$];

    desc_sort_pipe #(.NUM_VALS(N), .WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Reference: insertion sort, largest value into slot 0.
    function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] d);
        logic [W-1:0] a[N];
        logic [W-1:0] t;
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) a[i] = d[i*W +: W];
        for (int i = 1; i < N; i++) begin
            t = a[i];
            for (int j = i; j > 0; j--) begin
                if (a[j-1] < t) begin
                    a[j] = a[j-1];
                    a[j-1] = t;
                end
            end
        end
        for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
        return r;
    endfunction

    // Driver: present one set and queue its expected result.
    task automatic send(input logic [N*W-1:0] d, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        exp_q.push_back(ref_sort(d));
        due_q.push_back(cyc + LAT);
        tag_q.push_back(tag);
    endtask

    // Idle cycles with in_valid low and changing data (R5).
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            for (int i = 0; i < N; i++) in_data[i*W +: W] = W'($urandom);
        end
    endtask

    function automatic logic [N*W-1:0] pack9(input int v0, v1, v2, v3, v4, v5, v6, v7, v8);
        logic [N*W-1:0] r;
        r[0*W +: W] = W'(v0); r[1*W +: W] = W'(v1); r[2*W +: W] = W'(v2);
        r[3*W +: W] = W'(v3); r[4*W +: W] = W'(v4); r[5*W +: W] = W'(v5);
        r[6*W +: W] = W'(v6); r[7*W +: W] = W'(v7); r[8*W +: W] = W'(v8);
        return r;
    endfunction

    // Monitor: compare valid timing and data against the scoreboard.
    always @(negedge clk) begin
        if (mon_on && !done) begin
            bit ev;
            ev = (due_q.size() > 0) && (due_q[0] == cyc);
            if (ev) begin
                check(out_valid == 1'b1, "R3", {"valid missing for ", tag_q[0]},
                      {{(N*W-1){1'b0}}, out_valid}, {{(N*W-1){1'b0}}, 1'b1});
                check(out_data == exp_q[0], tag_q[0], "sorted data", out_data, exp_q[0]);
                void'(exp_q.pop_front());
                void'(due_q.pop_front());
                void'(tag_q.pop_front());
            end else begin
                check(out_valid == 1'b0, "R5", "unexpected valid",
                      {{(N*W-1){1'b0}}, out_valid}, '0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (!done && cyc > 20000) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] d;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        // R8: out_valid low while reset is held, even with in_valid high.
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            in_valid = (k > 2);
            check(out_valid == 1'b0, "R8", "valid during reset",
                  {{(N*W-1){1'b0}}, out_valid}, '0);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        mon_on = 1;
        idle(3);

        send(pack9(1, 2, 3, 4, 5, 6, 7, 8, 9), "R1 ascending");
        send(pack9(90, 80, 70, 60, 50, 40, 30, 20, 10), "R1 descending");
        send(pack9(5, 5, 5, 5, 5, 5, 5, 5, 5), "R2 all equal");
        send(pack9(3, 7, 3, 1, 7, 7, 0, 3, 1), "R2 duplicates");
        send(pack9(0, 0, 0, 0, 0, 0, 0, 0, 0), "R7 all zero");
        send(pack9(0, 4, 0, 2, 0, 0, 9, 0, 1), "R7 zero mix");
        send(pack9('h8000, 'h7FFF, 'hFFFF, 1, 'h8001, 0, 'h7FFE, 'hC000, 'h4000), "R6 top bit");
        idle(4);
        send(pack9(12, 400, 3, 3, 65535, 0, 77, 1, 9), "R5 after gap");
        idle(1);
        send(pack9(2, 1, 4, 3, 6, 5, 8, 7, 0), "R5 between gaps");
        idle(2);

        for (int r = 0; r < 200; r++) begin
            for (int i = 0; i < N; i++)
                d[i*W +: W] = (r % 3 == 0) ? W'($urandom_range(0, 3)) : W'($urandom);
            send(d, "R4 back-to-back");
        end
        idle(LAT + 4);

        check(exp_q.size() == 0, "R4", "results left undelivered",
              N*W'(exp_q.size()), '0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule